// File: doc/BRIEF.md
# LCD Line Pulse Timing Generator

This block produces the horizontal line-sync pulse for an LCD panel interface. It also reports where the scan currently sits: on an active display line, and inside the display part of that line. It advances only on cycles where the pixel enable is high. Enabled pixels are grouped into 8-pixel units, and a line is a whole number of units long.

Each line opens with its non-display (blanking) period, and the display period follows it. The line pulse starts at a programmed unit inside the blanking period. Its length depends on the panel type:

- On active-matrix panels, the length comes from a 4-bit width field, in 8-pixel steps.
- On passive panels, the pulse always lasts one unit.

A single polarity bit selects the active level of the pulse. The same bit value gives opposite levels on the two panel types.

A line counter advances at the end of each line and wraps after a programmed last line. The first height+1 lines of each frame are flagged as active. All settings are copied into shadow registers at each frame start, so the current frame never sees a mid-frame write.

Top module: `linePulseGen`

## Requirements
- R1: The pulse level is (pulse window) XOR polarity XOR panelType, where panelType 1 is active-matrix. With polarity 1 the pulse is active-high on active-matrix panels and active-low on passive panels; with polarity 0 both levels are reversed.
- R2: On an active-matrix panel the pulse lasts (width field + 1) units of 8 enabled pixels each, from 8 to 128 pixels.
- R3: On a passive panel the pulse lasts exactly one unit, whatever the width field holds.
- R4: A line holds (hNonDisplay+1)+(hDisplay+1) units, numbered from 0, with the blanking units first. The pulse window covers units start+1 through start+widthUnits.
- R5: The line counter advances after the last unit of each line and returns to 0 after line vTotal. lineActive is high exactly on lines 0 through vHeight, which is vHeight+1 lines.
- R6: pixelActive is high only on active lines, during units numbered above hNonDisplay.
- R7: All configuration inputs are sampled at reset and at each frame start. Changing them mid-frame has no effect on the outputs until the next frame.
- R8: Counters advance only on cycles with pixEn high. A unit is 8 enabled pixels, however many idle cycles fall between them.
- R9: A synchronous reset clears all counters and the pulse window. While reset is held, linePulse sits at its inactive level, polarity XOR panelType.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixEn | input | 1 | Pixel enable; one pixel per high cycle |
| cfgActiveMatrix | input | 1 | Panel type: 1 active-matrix, 0 passive |
| cfgPolarity | input | 1 | Pulse polarity select |
| cfgPulseStart | input | HU_W | Unit before the first pulse unit |
| cfgPulseWidth | input | WID_W | Active-matrix pulse width minus one, in units |
| cfgHDisplay | input | HU_W | Display units per line minus one |
| cfgHNonDisplay | input | HU_W | Blanking units per line minus one |
| cfgVHeight | input | V_W | Active lines minus one |
| cfgVTotal | input | V_W | Last line number of a frame |
| linePulse | output | 1 | Line sync pulse |
| lineActive | output | 1 | Current line is in the active region |
| pixelActive | output | 1 | Current unit is display area on an active line |

## Verification
The bench uses the default parameters: 8-pixel units, a 6-bit unit field and a 10-bit line field. It programs short lines of 10 and 25 units and six-line frames, so many complete frames fit in a short run.

With these settings, every unit of the sampled lines can be checked. The run covers:

- both panel types under both polarity values;
- the minimum width and the full 16-unit width;
- the edge between the last active line and the first inactive line, and the frame wrap;
- a frame in which the pixel enable drops periodically.

Configuration writes land mid-frame, so the frame-boundary sampling rule is exercised on every change.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  // Strobes from the control counters to the pulse/region datapath.
  typedef struct packed {
    logic unitTick;   // last enabled pixel of an 8-pixel unit
    logic lineEnd;    // last pixel of the last unit of a line
    logic frameEnd;   // last pixel of the last line of a frame
    logic pulseSet;   // next unit opens the pulse window
    logic pulseClr;   // next unit closes the pulse window
  } lpgStrobes_t;
endpackage

// File: rtl/lpg_ctrl.sv
module lpg_ctrl
  import lpg_pkg::*;
#(
  parameter int UNIT_PIX = 8,
  parameter int HU_W     = 6,
  parameter int V_W      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pixEn,
  input  logic [HU_W-1:0]   shHDisp,
  input  logic [HU_W-1:0]   shHNon,
  input  logic [HU_W-1:0]   shStart,
  input  logic [HU_W:0]     shWidthUnits,
  input  logic [V_W-1:0]    shVTotal,
  output lpgStrobes_t       strb,
  output logic [HU_W:0]     hUnit,
  output logic [V_W-1:0]    lineCnt
);
  localparam int HC_W = HU_W + 1;

  logic          unitTick;
  logic [HC_W-1:0] lineLast;
  logic [HC_W-1:0] startU;
  logic [HC_W-1:0] stopU;

  assign lineLast = {1'b0, shHDisp} + {1'b0, shHNon} + HC_W'(1);
  assign startU   = {1'b0, shStart};
  assign stopU    = startU + shWidthUnits;

  generate
    if (UNIT_PIX == 1) begin : g_noPrescale
      assign unitTick = pixEn;
    end else begin : g_prescale
      localparam int SUB_W = $clog2(UNIT_PIX);
      logic [SUB_W-1:0] subCnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          subCnt <= '0;
        end else if (pixEn) begin
          if (subCnt == SUB_W'(UNIT_PIX - 1)) subCnt <= '0;
          else                                subCnt <= subCnt + SUB_W'(1);
        end
      end
      assign unitTick = pixEn && (subCnt == SUB_W'(UNIT_PIX - 1));
    end
  endgenerate

  always_comb begin
    strb.unitTick = unitTick;
    strb.lineEnd  = unitTick && (hUnit == lineLast);
    strb.frameEnd = strb.lineEnd && (lineCnt == shVTotal);
    strb.pulseSet = unitTick && (hUnit == startU);
    strb.pulseClr = unitTick && (hUnit == stopU);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hUnit   <= '0;
      lineCnt <= '0;
    end else if (unitTick) begin
      if (strb.lineEnd) begin
        hUnit <= '0;
        if (strb.frameEnd) lineCnt <= '0;
        else               lineCnt <= lineCnt + V_W'(1);
      end else begin
        hUnit <= hUnit + HC_W'(1);
      end
    end
  end

  // R4
  hunit_range_chk: assert property (@(posedge clk) disable iff (rst)
    hUnit <= lineLast);

  // R5
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    strb.frameEnd |=> (hUnit == '0 && lineCnt == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pixEn |=> ($stable(hUnit) && $stable(lineCnt)));
endmodule

// File: rtl/lpg_datapath.sv
module lpg_datapath
  import lpg_pkg::*;
#(
  parameter int HU_W  = 6,
  parameter int WID_W = 4,
  parameter int V_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  lpgStrobes_t       strb,
  input  logic [HU_W:0]     hUnit,
  input  logic [V_W-1:0]    lineCnt,
  input  logic              cfgActiveMatrix,
  input  logic              cfgPolarity,
  input  logic [HU_W-1:0]   cfgPulseStart,
  input  logic [WID_W-1:0]  cfgPulseWidth,
  input  logic [HU_W-1:0]   cfgHDisplay,
  input  logic [HU_W-1:0]   cfgHNonDisplay,
  input  logic [V_W-1:0]    cfgVHeight,
  input  logic [V_W-1:0]    cfgVTotal,
  output logic [HU_W-1:0]   shHDisp,
  output logic [HU_W-1:0]   shHNon,
  output logic [HU_W-1:0]   shStart,
  output logic [HU_W:0]     shWidthUnits,
  output logic [V_W-1:0]    shVTotal,
  output logic              linePulse,
  output logic              lineActive,
  output logic              pixelActive
);
  localparam int HC_W = HU_W + 1;

  logic             shAm;
  logic             shPol;
  logic [WID_W-1:0] shWidth;
  logic [V_W-1:0]   shHeight;
  logic             pulseFlag;

  // Shadow copy taken at reset and on each frame boundary.
  always_ff @(posedge clk) begin
    if (rst || strb.frameEnd) begin
      shAm     <= cfgActiveMatrix;
      shPol    <= cfgPolarity;
      shStart  <= cfgPulseStart;
      shWidth  <= cfgPulseWidth;
      shHDisp  <= cfgHDisplay;
      shHNon   <= cfgHNonDisplay;
      shHeight <= cfgVHeight;
      shVTotal <= cfgVTotal;
    end
  end

  assign shWidthUnits = shAm ? (HC_W'(shWidth) + HC_W'(1)) : HC_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                pulseFlag <= 1'b0;
    else if (strb.pulseSet) pulseFlag <= 1'b1;
    else if (strb.pulseClr) pulseFlag <= 1'b0;
  end

  assign linePulse   = pulseFlag ^ shPol ^ shAm;
  assign lineActive  = (lineCnt <= shHeight);
  assign pixelActive = lineActive && (hUnit > {1'b0, shHNon});

  // Checker state: units counted while the pulse window is open.
  logic [HC_W-1:0] pulseLen;
  always_ff @(posedge clk) begin
    if (rst || strb.pulseSet)             pulseLen <= '0;
    else if (strb.unitTick && pulseFlag)  pulseLen <= pulseLen + HC_W'(1);
  end

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulseFlag) |-> (hUnit == {1'b0, shStart} + HC_W'(1)));

  // R2, R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.pulseClr && pulseFlag) |-> (pulseLen + HC_W'(1) == shWidthUnits));

  // R9
  reset_level_chk: assert property (@(posedge clk)
    rst |=> (linePulse == (cfgPolarity ^ cfgActiveMatrix)) || !$stable(cfgPolarity)
            || !$stable(cfgActiveMatrix));
endmodule

// File: rtl/linePulseGen.sv
module linePulseGen
  import lpg_pkg::*;
#(
  parameter int UNIT_PIX = 8,
  parameter int HU_W     = 6,
  parameter int WID_W    = 4,
  parameter int V_W      = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixEn,
  input  logic             cfgActiveMatrix,
  input  logic             cfgPolarity,
  input  logic [HU_W-1:0]  cfgPulseStart,
  input  logic [WID_W-1:0] cfgPulseWidth,
  input  logic [HU_W-1:0]  cfgHDisplay,
  input  logic [HU_W-1:0]  cfgHNonDisplay,
  input  logic [V_W-1:0]   cfgVHeight,
  input  logic [V_W-1:0]   cfgVTotal,
  output logic             linePulse,
  output logic             lineActive,
  output logic             pixelActive
);
  lpgStrobes_t     strb;
  logic [HU_W:0]   hUnit;
  logic [V_W-1:0]  lineCnt;
  logic [HU_W-1:0] shHDisp;
  logic [HU_W-1:0] shHNon;
  logic [HU_W-1:0] shStart;
  logic [HU_W:0]   shWidthUnits;
  logic [V_W-1:0]  shVTotal;

  lpg_ctrl #(.UNIT_PIX(UNIT_PIX), .HU_W(HU_W), .V_W(V_W)) u_ctrl (
    .clk(clk), .rst(rst), .pixEn(pixEn),
    .shHDisp(shHDisp), .shHNon(shHNon), .shStart(shStart),
    .shWidthUnits(shWidthUnits), .shVTotal(shVTotal),
    .strb(strb), .hUnit(hUnit), .lineCnt(lineCnt)
  );

  lpg_datapath #(.HU_W(HU_W), .WID_W(WID_W), .V_W(V_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .hUnit(hUnit), .lineCnt(lineCnt),
    .cfgActiveMatrix(cfgActiveMatrix), .cfgPolarity(cfgPolarity),
    .cfgPulseStart(cfgPulseStart), .cfgPulseWidth(cfgPulseWidth),
    .cfgHDisplay(cfgHDisplay), .cfgHNonDisplay(cfgHNonDisplay),
    .cfgVHeight(cfgVHeight), .cfgVTotal(cfgVTotal),
    .shHDisp(shHDisp), .shHNon(shHNon), .shStart(shStart),
    .shWidthUnits(shWidthUnits), .shVTotal(shVTotal),
    .linePulse(linePulse), .lineActive(lineActive), .pixelActive(pixelActive)
  );
endmodule

// File: tb/linePulseGen_bench.sv
module linePulseGen_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic       rst = 1'b1;
  logic       pixEn = 1'b0;
  logic       am = 1'b1, pol = 1'b1;
  logic [5:0] pStart = 6'd1, hDisp = 6'd3, hNon = 6'd5;
  logic [3:0] pWidth = 4'd2;
  logic [9:0] vHeight = 10'd2, vTotal = 10'd5;
  logic       linePulse, lineActive, pixelActive;

  linePulseGen u_linePulseGen (
    .clk(clk), .rst(rst), .pixEn(pixEn),
    .cfgActiveMatrix(am), .cfgPolarity(pol),
    .cfgPulseStart(pStart), .cfgPulseWidth(pWidth),
    .cfgHDisplay(hDisp), .cfgHNonDisplay(hNon),
    .cfgVHeight(vHeight), .cfgVTotal(vTotal),
    .linePulse(linePulse), .lineActive(lineActive), .pixelActive(pixelActive)
  );

  typedef struct {
    int    pix;
    logic  pulse;
    logic  la;
    logic  pa;
    string tag;
  } item_t;

  item_t q[$];
  int nChecks = 0, nFail = 0, pix = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // Driver side: push expected levels for every unit of one line.
  task automatic pushLine(int base, int len, int nonLast, int line, int st,
                          int wU, logic p, logic t, int h, string tag);
    for (int u = 0; u < len; u++) begin
      item_t it;
      logic  win;
      win      = (u >= st + 1) && (u <= st + wU);
      it.pix   = base + (line * len + u) * 8 + 4;
      it.pulse = win ^ p ^ t;
      it.la    = (line <= h);
      it.pa    = it.la && (u > nonLast);
      it.tag   = tag;
      q.push_back(it);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst && pixEn) pix++;
  end

  // R8: idle cycles inside the second frame
  always @(negedge clk) begin
    if (!rst && pix >= 480) pixEn <= !(pix < 960 && (cyc % 3 == 0));
  end

  // Monitor: compare items once the enabled-pixel count reaches them.
  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0 && q[0].pix <= pix) begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, "linePulse",   linePulse,   it.pulse);
        chk(it.tag, "lineActive",  lineActive,  it.la);
        chk(it.tag, "pixelActive", pixelActive, it.pa);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    // Frame 1: active-matrix, polarity 1, units 2..4, lines 0..2 active (R1 R2 R4 R5 R6)
    pushLine(0, 10, 5, 0, 1, 3, 1'b1, 1'b1, 2, "R1 R2 R4");
    pushLine(0, 10, 5, 2, 1, 3, 1'b1, 1'b1, 2, "R7 R6");
    pushLine(0, 10, 5, 3, 1, 3, 1'b1, 1'b1, 2, "R5 R6");
    pushLine(0, 10, 5, 4, 1, 3, 1'b1, 1'b1, 2, "R5");
    // Frame 2: polarity 0, width field 0, with idle cycles (R1 R2 R8)
    pushLine(480, 10, 5, 0, 1, 1, 1'b0, 1'b1, 2, "R8 R2 R1");
    pushLine(480, 10, 5, 5, 1, 1, 1'b0, 1'b1, 2, "R8 R5");
    // Frame 3: passive, polarity 0, width field 15 ignored (R3 R1)
    pushLine(960, 10, 5, 0, 1, 1, 1'b0, 1'b0, 2, "R3 R1");
    // Frame 4: passive, polarity 1 -> active low (R1 R3)
    pushLine(1440, 10, 5, 3, 1, 1, 1'b1, 1'b0, 2, "R1 R3 R7");
    // Frame 5: full 16-unit width, longer blanking, taller region (R2 R4 R5 R6)
    pushLine(1920, 25, 20, 0, 0, 16, 1'b1, 1'b1, 4, "R2 R4");
    pushLine(1920, 25, 20, 4, 0, 16, 1'b1, 1'b1, 4, "R5 R6");
    pushLine(1920, 25, 20, 5, 0, 16, 1'b1, 1'b1, 4, "R5 R6");
    // Frame 6: after wrap, same settings (R5)
    pushLine(3120, 25, 20, 0, 0, 16, 1'b1, 1'b1, 4, "R5 R7");

    repeat (3) @(negedge clk);
    // R9: inactive level during reset, counters cleared
    chk("R9", "linePulse",   linePulse,   1'b0);
    chk("R9", "lineActive",  lineActive,  1'b1);
    chk("R9", "pixelActive", pixelActive, 1'b0);
    rst   = 1'b0;
    pixEn = 1'b1;

    wait (pix >= 100);  @(negedge clk);
    pWidth = 4'd0; pol = 1'b0;
    wait (pix >= 600);  @(negedge clk);
    am = 1'b0; pWidth = 4'd15;
    wait (pix >= 1100); @(negedge clk);
    pol = 1'b1;
    wait (pix >= 1500); @(negedge clk);
    am = 1'b1; pol = 1'b1; pStart = 6'd0; pWidth = 4'd15; hNon = 6'd20; vHeight = 10'd4;

    wait (q.size() == 0);
    @(negedge clk);
    finishRun();
  end
endmodule